// File: doc/BRIEF.md
# Chip-Select Cycle Generator for Asynchronous SRAM

This block runs one read or write cycle on an asynchronous SRAM-like device that sits behind one chip-select area of a local bus. A request carries an address, a read/write flag, byte enables and write data. It is taken only while the block is idle. The block first checks that the address falls inside its area. It then walks the cycle through a fixed sequence of phases: address setup, a delay from chip select to strobe, the strobe with its wait cycles, a delay from strobe to chip-select release, and address hold. At the end it reports completion.

Each phase length comes from a timing value. The timing values are captured together with the request, so the caller may change them once the request has been taken. A phase whose length is zero is skipped. The strobe phase can be stretched by an external ready input, but only when the configured wait count is nonzero. A bus-start pulse marks the start of the chip-select window. Read data is captured from the data bus in the final strobe cycle.

The data bus width is a parameter of 8, 16, 32 or 64 bits. It sets the number of byte write enables, from one to eight.

Top module: `cs_cycle_gen`

## Requirements
- R1: After reset, cs_n, rd_n, every bit of we_n and bs_n are high. done, err, busy and bus_wdata_oe are low, and bus_addr is zero.
- R2: A request is inside the area when req_addr bits [28:26] equal 3'b110. A request outside the area makes done and err high for one cycle, in the cycle after it is accepted. In that case cs_n, rd_n and we_n stay high and bus_addr stays zero.
- R3: For a request inside the area, cs_n is low for strb_dly + S + negate cycles, where S is the strobe length. bus_addr carries the request address for setup + strb_dly + S + negate + hold cycles. done rises in the cycle after the address stops being driven.
- R4: cs_n falls setup cycles after acceptance. The strobe starts strb_dly cycles after cs_n falls. cs_n rises negate cycles after the strobe ends.
- R5: With no ready stretching, the strobe lasts W + 1 cycles. W is cfg_wait clamped to at most 25.
- R6: When W > 0, the strobe is extended for as long as bus_rdy is low in its final counted cycle. When W = 0, bus_rdy has no effect.
- R7: For a read, rd_n is low during the strobe and all we_n bits stay high. rdata takes the value of bus_rdata from the final strobe cycle and holds it afterwards.
- R8: For a write, we_n[i] is low during the strobe exactly when req_be[i] = 1, and rd_n stays high. bus_wdata_oe is high, and bus_wdata equals the request data, for exactly the cycles in which cs_n is low.
- R9: bs_n is low in the first cs_n-low cycle. It is also low in the second cs_n-low cycle, but only when cfg_bs_long = 1 and cfg_strb_dly is nonzero.
- R10: busy is high from acceptance until done. done is a one-cycle pulse. A req_valid raised while busy is high starts no cycle and does not change the cycle in progress.
- R11: The timing inputs are sampled at acceptance. Changing them during the cycle does not change the phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | NBYTES | Byte enables for writes |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | 3 | Address setup cycles |
| cfg_strb_dly | input | 3 | Cycles from chip select to strobe |
| cfg_wait | input | 5 | Wait cycles, clamped to 25 |
| cfg_negate | input | 3 | Cycles from strobe end to chip-select release |
| cfg_hold | input | 3 | Address hold cycles |
| cfg_bs_long | input | 1 | Request a two-cycle bus-start pulse |
| bus_rdy | input | 1 | External ready, high = ready |
| bus_rdata | input | DATA_W | Read data from the device |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | NBYTES | Byte write enables, active low |
| bs_n | output | 1 | Bus-start pulse, active low |
| bus_addr | output | ADDR_W | Address to the device |
| bus_wdata | output | DATA_W | Write data to the device |
| bus_wdata_oe | output | 1 | Write data drive enable |
| rdata | output | DATA_W | Captured read data |
| done | output | 1 | Cycle complete pulse |
| err | output | 1 | Request outside the area, with done |
| busy | output | 1 | Cycle in progress |

## Verification
The embedded properties assume that req_valid is only meaningful while busy is low. They also assume that bus_rdy can be low indefinitely, so no property bounds the strobe length from above. The counter range property assumes that the timing inputs are captured only at acceptance.

The stimulus never relies on a request being taken while busy. It raises req_valid in the middle of a cycle only to confirm that the request is dropped. It drives bus_rdy low only for a fixed number of strobe cycles, so every cycle ends.

// File: rtl/cs_cycle_pkg.sv
package cs_cycle_pkg;

   localparam int TMR_W  = 3;
   localparam int WAIT_W = 5;
   localparam int CNT_W  = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_CSDLY,
      PH_STROBE,
      PH_NEGDLY,
      PH_HOLD,
      PH_DONE
   } phase_e;

   typedef struct packed {
      logic [TMR_W-1:0]  setup;
      logic [TMR_W-1:0]  strb_dly;
      logic [WAIT_W-1:0] wait_n;
      logic [TMR_W-1:0]  negate;
      logic [TMR_W-1:0]  hold;
      logic              bs_long;
   } timing_t;

   // Starting at phase p, return the first phase whose length is nonzero.
   function automatic phase_e first_live(input phase_e p, input timing_t t);
      phase_e r;
      case (p)
         PH_SETUP:  r = (t.setup != '0)    ? PH_SETUP :
                        (t.strb_dly != '0) ? PH_CSDLY : PH_STROBE;
         PH_CSDLY:  r = (t.strb_dly != '0) ? PH_CSDLY : PH_STROBE;
         PH_NEGDLY: r = (t.negate != '0)   ? PH_NEGDLY :
                        (t.hold != '0)     ? PH_HOLD : PH_DONE;
         PH_HOLD:   r = (t.hold != '0)     ? PH_HOLD : PH_DONE;
         default:   r = p;
      endcase
      return r;
   endfunction

   // Counter load value (phase length minus one) on entry to phase p.
   function automatic logic [CNT_W-1:0] phase_load(input phase_e p, input timing_t t);
      logic [CNT_W-1:0] r;
      case (p)
         PH_SETUP:  r = CNT_W'(t.setup)    - CNT_W'(1);
         PH_CSDLY:  r = CNT_W'(t.strb_dly) - CNT_W'(1);
         PH_STROBE: r = CNT_W'(t.wait_n);
         PH_NEGDLY: r = CNT_W'(t.negate)   - CNT_W'(1);
         PH_HOLD:   r = CNT_W'(t.hold)     - CNT_W'(1);
         default:   r = '0;
      endcase
      return r;
   endfunction

   function automatic logic in_cs_window(input phase_e p);
      return (p == PH_CSDLY) || (p == PH_STROBE) || (p == PH_NEGDLY);
   endfunction

   function automatic logic in_addr_window(input phase_e p);
      return (p != PH_IDLE) && (p != PH_DONE);
   endfunction

endpackage

// File: rtl/cs_phase_timer.sv
module cs_phase_timer #(
   parameter int CNT_W    = 5,
   parameter int MAX_LOAD = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   if (MAX_LOAD >= (1 << CNT_W)) begin : g_bad_width
      $error("cs_phase_timer: MAX_LOAD does not fit in CNT_W bits");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_LOAD));

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
   import cs_cycle_pkg::*;
#(
   parameter int          ADDR_W     = 29,
   parameter int          DATA_W     = 64,
   parameter int          NBYTES     = DATA_W / 8,
   parameter int          AREA_LSB   = 26,
   parameter logic [2:0]  AREA_CODE  = 3'b110,
   parameter int          WAIT_LIMIT = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [NBYTES-1:0] req_be,
   input  logic [DATA_W-1:0] req_wdata,
   input  timing_t           cfg_in,
   input  logic              bus_rdy,
   output phase_e            phase_o,
   output logic [ADDR_W-1:0] addr_q,
   output logic              write_q,
   output logic [NBYTES-1:0] be_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              miss_q,
   output logic              bs_active,
   output logic              strobe_last
);

   localparam int AGE_W = 2;

   phase_e             phase_q, phase_d;
   timing_t            cfg_q, cfg_clamped, cfg_sel;
   logic               area_hit;
   logic               tmr_load, tmr_expired;
   logic [CNT_W-1:0]   tmr_val;
   logic [AGE_W-1:0]   cs_age_q;
   logic               bs_two;

   always_comb begin
      cfg_clamped = cfg_in;
      if (cfg_in.wait_n > WAIT_W'(WAIT_LIMIT))
         cfg_clamped.wait_n = WAIT_W'(WAIT_LIMIT);
   end

   assign cfg_sel  = (phase_q == PH_IDLE) ? cfg_clamped : cfg_q;
   assign area_hit = (req_addr[AREA_LSB +: 3] == AREA_CODE);

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE:
            if (req_valid)
               phase_d = area_hit ? first_live(PH_SETUP, cfg_clamped) : PH_DONE;
         PH_SETUP:
            if (tmr_expired) phase_d = first_live(PH_CSDLY, cfg_q);
         PH_CSDLY:
            if (tmr_expired) phase_d = PH_STROBE;
         PH_STROBE:
            if (tmr_expired && ((cfg_q.wait_n == '0) || bus_rdy))
               phase_d = first_live(PH_NEGDLY, cfg_q);
         PH_NEGDLY:
            if (tmr_expired) phase_d = first_live(PH_HOLD, cfg_q);
         PH_HOLD:
            if (tmr_expired) phase_d = PH_DONE;
         PH_DONE:
            phase_d = PH_IDLE;
         default:
            phase_d = PH_IDLE;
      endcase
   end

   assign tmr_load = (phase_d != phase_q);
   assign tmr_val  = phase_load(phase_d, cfg_sel);

   cs_phase_timer #(
      .CNT_W   (CNT_W),
      .MAX_LOAD(WAIT_LIMIT)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cfg_q   <= '0;
         addr_q  <= '0;
         write_q <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
         miss_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && req_valid) begin
            cfg_q   <= cfg_clamped;
            addr_q  <= req_addr;
            write_q <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            miss_q  <= !area_hit;
         end
      end
   end

   // Age of the chip-select window, saturating, for the bus-start pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cs_age_q <= '0;
      else if (!in_cs_window(phase_q))
         cs_age_q <= '0;
      else if (cs_age_q != '1)
         cs_age_q <= cs_age_q + AGE_W'(1);
   end

   assign bs_two      = cfg_q.bs_long && (cfg_q.strb_dly != '0);
   assign bs_active   = in_cs_window(phase_q) &&
                        ((cs_age_q == '0) || ((cs_age_q == AGE_W'(1)) && bs_two));
   assign strobe_last = (phase_q == PH_STROBE) && (phase_d != PH_STROBE);
   assign phase_o     = phase_q;

   // R6
   rdy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE && tmr_expired && cfg_q.wait_n == '0) |=> (phase_q != PH_STROBE));

   // R2
   miss_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && req_valid && !area_hit) |=> (phase_q == PH_DONE));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && phase_q != PH_DONE) |=> $stable(addr_q));

endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive
   import cs_cycle_pkg::*;
#(
   parameter int ADDR_W = 29,
   parameter int DATA_W = 64,
   parameter int NBYTES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              write_q,
   input  logic [NBYTES-1:0] be_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              miss_q,
   input  logic              bs_active,
   input  logic              strobe_last,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              cs_n,
   output logic              rd_n,
   output logic [NBYTES-1:0] we_n,
   output logic              bs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wdata_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              err,
   output logic              busy
);

   logic cs_on, str_on;

   assign cs_on  = in_cs_window(phase);
   assign str_on = (phase == PH_STROBE);

   assign cs_n = !cs_on;
   assign rd_n = !(str_on && !write_q);
   assign bs_n = !bs_active;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign we_n[b] = !(str_on && write_q && be_q[b]);
   end

   assign bus_addr     = in_addr_window(phase) ? addr_q : '0;
   assign bus_wdata_oe = cs_on && write_q;
   assign bus_wdata    = bus_wdata_oe ? wdata_q : '0;
   assign done         = (phase == PH_DONE);
   assign err          = done && miss_q;
   assign busy         = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rdata <= '0;
      else if (strobe_last && !write_q) rdata <= bus_rdata;
   end

   // R3
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || (we_n != '1)) |-> !cs_n);

   // R7
   rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (we_n == '1));

   // R9
   bs_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bs_n |-> !cs_n);

   // R8
   oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wdata_oe |-> !cs_n);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && cs_n));

endmodule

// File: rtl/cs_cycle_gen.sv
module cs_cycle_gen
   import cs_cycle_pkg::*;
#(
   parameter int         ADDR_W     = 29,
   parameter int         DATA_W     = 64,
   parameter int         AREA_LSB   = 26,
   parameter logic [2:0] AREA_CODE  = 3'b110,
   parameter int         WAIT_LIMIT = 25,
   localparam int        NBYTES     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [NBYTES-1:0] req_be,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [2:0]        cfg_setup,
   input  logic [2:0]        cfg_strb_dly,
   input  logic [4:0]        cfg_wait,
   input  logic [2:0]        cfg_negate,
   input  logic [2:0]        cfg_hold,
   input  logic              cfg_bs_long,
   input  logic              bus_rdy,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              cs_n,
   output logic              rd_n,
   output logic [NBYTES-1:0] we_n,
   output logic              bs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wdata_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              err,
   output logic              busy
);

   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_bus
      $error("cs_cycle_gen: DATA_W must be 8, 16, 32 or 64");
   end
   if (AREA_LSB + 3 > ADDR_W) begin : g_bad_area
      $error("cs_cycle_gen: area field exceeds the address width");
   end
   if (WAIT_LIMIT >= (1 << WAIT_W)) begin : g_bad_wait
      $error("cs_cycle_gen: WAIT_LIMIT exceeds the wait field");
   end

   timing_t           cfg;
   phase_e            phase;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q, miss_q, bs_active, strobe_last;
   logic [NBYTES-1:0] be_q;
   logic [DATA_W-1:0] wdata_q;

   assign cfg = '{setup: cfg_setup, strb_dly: cfg_strb_dly, wait_n: cfg_wait,
                  negate: cfg_negate, hold: cfg_hold, bs_long: cfg_bs_long};

   cs_seq_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NBYTES    (NBYTES),
      .AREA_LSB  (AREA_LSB),
      .AREA_CODE (AREA_CODE),
      .WAIT_LIMIT(WAIT_LIMIT)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_be     (req_be),
      .req_wdata  (req_wdata),
      .cfg_in     (cfg),
      .bus_rdy    (bus_rdy),
      .phase_o    (phase),
      .addr_q     (addr_q),
      .write_q    (write_q),
      .be_q       (be_q),
      .wdata_q    (wdata_q),
      .miss_q     (miss_q),
      .bs_active  (bs_active),
      .strobe_last(strobe_last)
   );

   cs_pin_drive #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .NBYTES(NBYTES)
   ) i_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .addr_q      (addr_q),
      .write_q     (write_q),
      .be_q        (be_q),
      .wdata_q     (wdata_q),
      .miss_q      (miss_q),
      .bs_active   (bs_active),
      .strobe_last (strobe_last),
      .bus_rdata   (bus_rdata),
      .cs_n        (cs_n),
      .rd_n        (rd_n),
      .we_n        (we_n),
      .bs_n        (bs_n),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_wdata_oe(bus_wdata_oe),
      .rdata       (rdata),
      .done        (done),
      .err         (err),
      .busy        (busy)
   );

endmodule

// File: tb/test_cs_cycle_gen.sv
module test_cs_cycle_gen;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 29;
   localparam int DATA_W = 64;
   localparam int NB     = DATA_W / 8;
   localparam int NVEC   = 10;

   typedef struct packed {
      logic [2:0] setup;
      logic [2:0] dly;
      logic [4:0] wt;
      logic [2:0] neg;
      logic [2:0] hold;
      logic       bsl;
      logic       wr;
      logic [7:0] be;
      logic       miss;
      logic [2:0] stretch;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 3'd0, 5'd0,  3'd0, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 3'd0},
      '{3'd1, 3'd2, 5'd3,  3'd1, 3'd2, 1'b1, 1'b1, 8'h0F, 1'b0, 3'd0},
      '{3'd2, 3'd1, 5'd5,  3'd3, 3'd1, 1'b1, 1'b0, 8'hFF, 1'b0, 3'd2},
      '{3'd7, 3'd7, 5'd25, 3'd7, 3'd7, 1'b1, 1'b1, 8'hA5, 1'b0, 3'd0},
      '{3'd0, 3'd0, 5'd0,  3'd0, 3'd0, 1'b1, 1'b1, 8'h01, 1'b0, 3'd3},
      '{3'd3, 3'd0, 5'd31, 3'd2, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 3'd0},
      '{3'd1, 3'd3, 5'd2,  3'd0, 3'd4, 1'b0, 1'b1, 8'hFF, 1'b0, 3'd1},
      '{3'd2, 3'd2, 5'd2,  3'd2, 3'd2, 1'b0, 1'b0, 8'hFF, 1'b1, 3'd0},
      '{3'd0, 3'd4, 5'd1,  3'd0, 3'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 3'd4},
      '{3'd5, 3'd0, 5'd0,  3'd6, 3'd0, 1'b0, 1'b1, 8'hC3, 1'b0, 3'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic [NB-1:0]     req_be = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [2:0]        cfg_setup = '0, cfg_strb_dly = '0, cfg_negate = '0, cfg_hold = '0;
   logic [4:0]        cfg_wait = '0;
   logic              cfg_bs_long = 1'b0;
   logic              bus_rdy = 1'b1;
   logic [DATA_W-1:0] bus_rdata = '0;
   logic              cs_n, rd_n, bs_n, bus_wdata_oe, done, err, busy;
   logic [NB-1:0]     we_n;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata, rdata;

   int n_chk = 0;
   int n_bad = 0;
   int cur   = -1;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_cycle_gen i_cs_cycle_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
      .cfg_setup(cfg_setup), .cfg_strb_dly(cfg_strb_dly), .cfg_wait(cfg_wait),
      .cfg_negate(cfg_negate), .cfg_hold(cfg_hold), .cfg_bs_long(cfg_bs_long),
      .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .cs_n(cs_n), .rd_n(rd_n),
      .we_n(we_n), .bs_n(bs_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wdata_oe(bus_wdata_oe), .rdata(rdata), .done(done), .err(err), .busy(busy)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s vec %0d: got %h expected %h", rq, cur, act, exp);
      end
   endtask

   function automatic logic [63:0] rd_pat(input int k);
      return {8{8'(8'hA0 + k)}} ^ 64'h0F1E_2D3C_4B5A_6978;
   endfunction

   task automatic run_vec(input vec_t v, input int idx);
      logic [ADDR_W-1:0] a;
      logic [63:0]       wd;
      int w, lstr, t, cs_cnt, st_cnt, bs_cnt, ad_cnt;
      int f_cs, f_st, l_cs, l_st, f_bs, t_done;
      int pat_bad, oe_bad, ad_bad, busy_bad, err_seen;
      bit fin;
      cur = idx;
      a  = {(v.miss ? 3'b010 : 3'b110), 26'(idx * 26'h0041_000 + 26'h123)};
      wd = 64'hC0DE_0000_0000_0000 | (64'(idx + 1) * 64'h0101_0101);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = v.wr; req_be = v.be; req_wdata = wd;
      cfg_setup = v.setup; cfg_strb_dly = v.dly; cfg_wait = v.wt;
      cfg_negate = v.neg; cfg_hold = v.hold; cfg_bs_long = v.bsl;
      bus_rdy = (v.stretch == 0); bus_rdata = rd_pat(0);
      @(negedge clk);
      req_valid = 1'b0;
      // R11: timing inputs change after acceptance
      cfg_setup = 3'd7; cfg_strb_dly = 3'd7; cfg_wait = 5'd9;
      cfg_negate = 3'd7; cfg_hold = 3'd7; cfg_bs_long = ~v.bsl;
      t = 1; cs_cnt = 0; st_cnt = 0; bs_cnt = 0; ad_cnt = 0;
      f_cs = -1; f_st = -1; l_cs = -1; l_st = -1; f_bs = -1; t_done = -1;
      pat_bad = 0; oe_bad = 0; ad_bad = 0; busy_bad = 0; err_seen = 0;
      w = (v.wt > 25) ? 25 : int'(v.wt);
      fin = 1'b0;
      while (!fin) begin
         logic strobe;
         strobe = v.wr ? (we_n != '1) : !rd_n;
         if (!cs_n) begin cs_cnt++; if (f_cs < 0) f_cs = t; l_cs = t; end
         if (strobe) begin st_cnt++; if (f_st < 0) f_st = t; l_st = t; end
         if (!bs_n) begin bs_cnt++; if (f_bs < 0) f_bs = t; end
         if (bus_addr != '0) begin ad_cnt++; if (bus_addr !== a) ad_bad++; end
         if (strobe && v.wr && (we_n !== ~v.be[NB-1:0])) pat_bad++;
         if (v.wr && !rd_n) pat_bad++;
         if (!v.wr && we_n != '1) pat_bad++;
         if (bus_wdata_oe !== (v.wr && !cs_n)) oe_bad++;
         if (bus_wdata_oe && bus_wdata !== wd) oe_bad++;
         if (!done && !busy) busy_bad++;
         if (done) begin
            t_done = t; err_seen = int'(err); fin = 1'b1;
         end else begin
            if (v.stretch != 0) bus_rdy = strobe && (st_cnt >= w + 1 + int'(v.stretch));
            bus_rdata = strobe ? rd_pat(st_cnt) : rd_pat(0);
            // R10: a request raised while busy must be dropped
            if (t == 2) begin
               req_valid = 1'b1; req_addr = {3'b110, 26'h0123456}; req_write = ~v.wr;
            end
            if (t == 3) req_valid = 1'b0;
            if (t > 300) begin fin = 1'b1; t_done = -2; end
            t++;
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
      lstr = w + 1 + ((w > 0) ? int'(v.stretch) : 0);
      if (v.miss) begin
         chk("R2 done latency", 64'(t_done), 64'd1);
         chk("R2 err", 64'(err_seen), 64'd1);
         chk("R2 no cs", 64'(cs_cnt + st_cnt), 64'd0);
         chk("R2 no addr", 64'(ad_cnt), 64'd0);
      end else begin
         int e_cs, e_ad;
         e_cs = int'(v.dly) + lstr + int'(v.neg);
         e_ad = int'(v.setup) + e_cs + int'(v.hold);
         chk("R3 R11 cs cycles", 64'(cs_cnt), 64'(e_cs));
         chk("R3 R11 addr cycles", 64'(ad_cnt), 64'(e_ad));
         chk("R3 addr value", 64'(ad_bad), 64'd0);
         chk("R3 done time", 64'(t_done), 64'(e_ad + 1));
         chk("R2 no err", 64'(err_seen), 64'd0);
         chk("R4 cs start", 64'(f_cs), 64'(int'(v.setup) + 1));
         chk("R4 strobe start", 64'(f_st), 64'(int'(v.setup) + int'(v.dly) + 1));
         chk("R4 cs end", 64'(l_cs), 64'(l_st + int'(v.neg)));
         if (v.stretch != 0) chk("R6 strobe length", 64'(st_cnt), 64'(lstr));
         else                chk("R5 strobe length", 64'(st_cnt), 64'(lstr));
         chk("R9 bs cycles", 64'(bs_cnt), ((v.bsl && v.dly != 0) ? 64'd2 : 64'd1));
         chk("R9 bs start", 64'(f_bs), 64'(f_cs));
         if (v.wr) chk("R8 write enables", 64'(pat_bad), 64'd0);
         else begin
            chk("R7 read strobes", 64'(pat_bad), 64'd0);
            chk("R7 read data", rdata, rd_pat(lstr));
         end
         chk("R8 write data drive", 64'(oe_bad), 64'd0);
      end
      chk("R10 busy until done", 64'(busy_bad), 64'd0);
      @(negedge clk);
      chk("R10 done pulse", {62'd0, done, busy}, 64'd0);
      chk("R10 no new cycle", {63'd0, cs_n}, 64'd1);
      bus_rdy = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 strobes", {60'd0, cs_n, rd_n, bs_n, &we_n}, 64'hF);
      chk("R1 status", {60'd0, done, err, busy, bus_wdata_oe}, 64'h0);
      chk("R1 address", 64'(bus_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);
      // R7: a later write leaves rdata untouched
      cur = 100;
      begin
         logic [63:0] keep;
         keep = rdata;
         run_vec('{3'd0, 3'd1, 5'd2, 3'd0, 3'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 3'd0}, 100);
         chk("R7 rdata held over write", rdata, keep);
      end
      // R6: wait of 1 with a long ready stall
      run_vec('{3'd0, 3'd0, 5'd1, 3'd0, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 3'd7}, 101);
      // R1: reset in the middle of a cycle returns to the reset state
      cur = 102;
      @(negedge clk);
      req_valid = 1'b1; req_addr = {3'b110, 26'h55}; req_write = 1'b1; req_be = '1;
      cfg_setup = 3'd1; cfg_strb_dly = 3'd1; cfg_wait = 5'd4; cfg_negate = 3'd1; cfg_hold = 3'd1;
      @(negedge clk); req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-cycle reset", {59'd0, cs_n, &we_n, bs_n, busy, bus_wdata_oe}, 64'h1C);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, got hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule